// File: doc/BRIEF.md
# Fixed-Point DSP Register Bank with Guarded Accumulators

This block is the register storage of a fixed-point signal-processing unit. It keeps two 40-bit accumulators, six 32-bit operand registers and one 32-bit control word. Each accumulator is a 32-bit body plus an 8-bit guard byte. Four independent access paths share the storage:

- an arithmetic path with two operand read ports and one writeback port;
- a half-word memory transfer path, with separate X-side and Y-side load ports and one store read-out;
- a single-data transfer path that works in word or longword mode;
- a system path that reaches only a small subset of the registers.

Each path applies its own rules. These rules cover which registers it may touch, how data is sign-extended or truncated, and which half-word is cleared on a load. The block checks every enabled access against the rules of its path. When an access breaks those rules, the block discards every write of that cycle and raises a one-cycle flag. All reads are combinational, so a read always returns the contents from before the clock edge that commits the writes. When several paths write the same field in one cycle, a fixed priority decides which value is kept.

Top module: `dsp_reg_bank`

## Requirements
- R1: A synchronous active-high `rst` clears every register body, both guard bytes, the control word and `illegalFlag`.
- R2: Register codes are 0=ACC0, 1=ACC1, 2=XR0, 3=XR1, 4=YR0, 5=YR1, 6=MR0 and 7=MR1. An arithmetic operand read of an accumulator returns its guard byte in bits 39:32 and its body in bits 31:0. A read of any other register returns its 32-bit value with bit 31 copied into bits 39:32.
- R3: An arithmetic writeback to an accumulator stores all 40 bits. A writeback to any other register stores bits 31:0 and discards bits 39:32.
- R4: An X-side load is legal only into codes 2 and 3, and a Y-side load only into codes 4 and 5. A load writes its 16-bit data into bits 31:16 and clears bits 15:0.
- R5: The half-word store is legal only from codes 0 and 1. `xyStData` returns bits 31:16 of the selected accumulator, and 0 for any other code.
- R6: The transfer select `sdtSel` uses codes 0–7 as in R2, 8=guard of ACC0 and 9=guard of ACC1. A word-mode load into codes 0–7 writes bits 31:16 from `sdtWrData[15:0]` and clears bits 15:0. For codes 0 and 1 it also fills the guard byte with `sdtWrData[15]`.
- R7: A word-mode load into code 8 or 9 writes `sdtWrData[7:0]` into that guard byte only. The accumulator body is left unchanged.
- R8: A longword-mode load into codes 0–7 writes all 32 bits. For codes 0 and 1 it also fills the guard byte with `sdtWrData[31]`. An enabled transfer with code 10–15, or with code 8 or 9 in longword mode, is illegal.
- R9: `sdtRdData` depends on the mode and code:
  - longword mode, codes 0–7: the register's bits 31:0;
  - word mode, codes 0–7: bits 31:16 in the low half, with zeros above;
  - codes 8 and 9: the guard byte sign-extended to 32 bits;
  - any other case: 0.
- R10: The system path uses `sysSel` codes 0=control word, 1=ACC0, 2=XR0, 3=XR1, 4=YR0 and 5=YR1; codes 6 and 7 are illegal. A write stores 32 bits, and a write to ACC0 fills its guard byte with bit 31. `sysRdData` returns bits 31:0 of the selected register, or 0 for codes 6 and 7.
- R11: If any enabled access breaks its path's rules, no register changes at that edge, and `illegalFlag` is high for exactly the following cycle.
- R12: Writes that target the same field in one cycle are resolved with priority system > single transfer > half-word load > arithmetic. The guard byte and the body are resolved separately. Reads in that cycle return the values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aluRdSelA | input | 3 | Operand A register code |
| aluRdDataA | output | 40 | Operand A value |
| aluRdSelB | input | 3 | Operand B register code |
| aluRdDataB | output | 40 | Operand B value |
| aluWrEn | input | 1 | Arithmetic writeback enable |
| aluWrSel | input | 3 | Writeback register code |
| aluWrData | input | 40 | Writeback value |
| xLdEn | input | 1 | X-side half-word load enable |
| xLdSel | input | 3 | X-side load target code |
| xLdData | input | 16 | X-side load data |
| yLdEn | input | 1 | Y-side half-word load enable |
| yLdSel | input | 3 | Y-side load target code |
| yLdData | input | 16 | Y-side load data |
| xyStEn | input | 1 | Half-word store enable (legality check) |
| xyStSel | input | 3 | Half-word store source code |
| xyStData | output | 16 | Half-word store data |
| sdtEn | input | 1 | Single transfer enable |
| sdtWrite | input | 1 | 1 = load into register, 0 = read out |
| sdtLong | input | 1 | 1 = longword mode, 0 = word mode |
| sdtSel | input | 4 | Single transfer register code |
| sdtWrData | input | 32 | Single transfer load data |
| sdtRdData | output | 32 | Single transfer read data |
| sysEn | input | 1 | System path enable |
| sysWrite | input | 1 | 1 = write, 0 = read |
| sysSel | input | 3 | System path register code |
| sysWrData | input | 32 | System path write data |
| sysRdData | output | 32 | System path read data |
| illegalFlag | output | 1 | Pulse for one cycle after a rule violation |

## Verification
The collisions that matter most are an arithmetic writeback and a transfer load hitting the same accumulator in the same cycle. A related case is a guard-only word load meeting a full 40-bit writeback: here the guard byte and the body must resolve separately. Directed cycles drive these collisions deliberately, and a random phase keeps all paths busy at once with legal codes most of the time. A behavioural model in the bench applies the paths in priority order, field by field. Every clock, the model is compared against all read ports and the illegal flag, so a lost, misordered or wrongly extended write shows up on the next read of that register.

// File: rtl/dsp_reg_pkg.sv
package dsp_reg_pkg;
  localparam int BODY_W   = 32;
  localparam int GUARD_W  = 8;
  localparam int HALF_W   = BODY_W / 2;
  localparam int WIDE_W   = BODY_W + GUARD_W;
  localparam int NUM_REGS = 8;
  localparam int NUM_ACC  = 2;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int SDT_SEL_W = SEL_W + 1;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_ALU, SRC_XMEM, SRC_YMEM, SRC_SDT, SRC_SYS
  } src_e;

  typedef struct packed {
    src_e [NUM_REGS-1:0] loSrc;
    src_e [NUM_ACC-1:0]  grdSrc;
    logic                ctlWr;
    logic                veto;
  } wr_strobe_t;
endpackage

// File: rtl/dsp_reg_ctrl.sv
module dsp_reg_ctrl
  import dsp_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 aluWrEn,
  input  logic [SEL_W-1:0]     aluWrSel,
  input  logic                 xLdEn,
  input  logic [SEL_W-1:0]     xLdSel,
  input  logic                 yLdEn,
  input  logic [SEL_W-1:0]     yLdSel,
  input  logic                 xyStEn,
  input  logic [SEL_W-1:0]     xyStSel,
  input  logic                 sdtEn,
  input  logic                 sdtWrite,
  input  logic                 sdtLong,
  input  logic [SDT_SEL_W-1:0] sdtSel,
  input  logic                 sysEn,
  input  logic                 sysWrite,
  input  logic [SEL_W-1:0]     sysSel,
  output wr_strobe_t           strobe,
  output logic                 illegalFlag
);
  localparam int ACC_LAST  = NUM_ACC - 1;
  localparam int GRD_FIRST = NUM_REGS;
  localparam int GRD_LAST  = NUM_REGS + NUM_ACC - 1;
  localparam int SYS_LAST  = 5;

  logic xBad, yBad, stBad, sdtBad, sysBad, violation;

  // Per-path legality (R4, R5, R8, R10)
  assign xBad   = xLdEn  && !(xLdSel == SEL_W'(2) || xLdSel == SEL_W'(3));
  assign yBad   = yLdEn  && !(yLdSel == SEL_W'(4) || yLdSel == SEL_W'(5));
  assign stBad  = xyStEn && (int'(xyStSel) > ACC_LAST);
  assign sdtBad = sdtEn  && ((int'(sdtSel) > GRD_LAST) ||
                             (sdtLong && int'(sdtSel) >= GRD_FIRST));
  assign sysBad = sysEn  && (int'(sysSel) > SYS_LAST);
  assign violation = xBad || yBad || stBad || sdtBad || sysBad;

  // Later statements override earlier ones: sys > sdt > xy > alu (R12)
  always_comb begin
    strobe = '0;
    strobe.veto = violation;
    if (!violation) begin
      if (aluWrEn) begin
        strobe.loSrc[aluWrSel] = SRC_ALU;
        if (int'(aluWrSel) <= ACC_LAST) strobe.grdSrc[aluWrSel[0]] = SRC_ALU;
      end
      if (xLdEn) strobe.loSrc[xLdSel] = SRC_XMEM;
      if (yLdEn) strobe.loSrc[yLdSel] = SRC_YMEM;
      if (sdtEn && sdtWrite) begin
        if (int'(sdtSel) >= GRD_FIRST) begin
          strobe.grdSrc[sdtSel[0]] = SRC_SDT;
        end else begin
          strobe.loSrc[sdtSel[SEL_W-1:0]] = SRC_SDT;
          if (int'(sdtSel) <= ACC_LAST) strobe.grdSrc[sdtSel[0]] = SRC_SDT;
        end
      end
      if (sysEn && sysWrite) begin
        if (sysSel == '0) begin
          strobe.ctlWr = 1'b1;
        end else if (sysSel == SEL_W'(1)) begin
          strobe.loSrc[0]  = SRC_SYS;
          strobe.grdSrc[0] = SRC_SYS;
        end else begin
          strobe.loSrc[sysSel] = SRC_SYS;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) illegalFlag <= 1'b0;
    else     illegalFlag <= violation;
  end

  // R11: flag follows a violation by exactly one cycle
  a_r11_flag_raised: assert property (@(posedge clk) disable iff (rst)
    violation |=> illegalFlag);
  a_r11_flag_single: assert property (@(posedge clk) disable iff (rst)
    !violation |=> !illegalFlag);
endmodule

// File: rtl/dsp_reg_data.sv
module dsp_reg_data
  import dsp_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  wr_strobe_t           strobe,
  input  logic [SEL_W-1:0]     aluRdSelA,
  output logic [WIDE_W-1:0]    aluRdDataA,
  input  logic [SEL_W-1:0]     aluRdSelB,
  output logic [WIDE_W-1:0]    aluRdDataB,
  input  logic [WIDE_W-1:0]    aluWrData,
  input  logic [HALF_W-1:0]    xLdData,
  input  logic [HALF_W-1:0]    yLdData,
  input  logic [SEL_W-1:0]     xyStSel,
  output logic [HALF_W-1:0]    xyStData,
  input  logic                 sdtLong,
  input  logic [SDT_SEL_W-1:0] sdtSel,
  input  logic [BODY_W-1:0]    sdtWrData,
  output logic [BODY_W-1:0]    sdtRdData,
  input  logic [SEL_W-1:0]     sysSel,
  input  logic [BODY_W-1:0]    sysWrData,
  output logic [BODY_W-1:0]    sysRdData
);
  localparam int ACC_LAST  = NUM_ACC - 1;
  localparam int GRD_FIRST = NUM_REGS;
  localparam int GRD_LAST  = NUM_REGS + NUM_ACC - 1;

  logic [NUM_REGS-1:0][BODY_W-1:0] loReg;
  logic [NUM_ACC-1:0][GUARD_W-1:0] grdReg;
  logic [BODY_W-1:0]               ctlReg;

  logic [BODY_W-1:0]  sdtBodyVal;
  logic [GUARD_W-1:0] sdtGrdVal;

  // R6/R7/R8: single transfer data shaping
  assign sdtBodyVal = sdtLong ? sdtWrData : {sdtWrData[HALF_W-1:0], {HALF_W{1'b0}}};
  assign sdtGrdVal  = (int'(sdtSel) >= GRD_FIRST) ? sdtWrData[GUARD_W-1:0] :
                      sdtLong ? {GUARD_W{sdtWrData[BODY_W-1]}} :
                                {GUARD_W{sdtWrData[HALF_W-1]}};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_body
    always_ff @(posedge clk) begin
      if (rst) loReg[i] <= '0;
      else begin
        case (strobe.loSrc[i])
          SRC_ALU:  loReg[i] <= aluWrData[BODY_W-1:0];
          SRC_XMEM: loReg[i] <= {xLdData, {HALF_W{1'b0}}};
          SRC_YMEM: loReg[i] <= {yLdData, {HALF_W{1'b0}}};
          SRC_SDT:  loReg[i] <= sdtBodyVal;
          SRC_SYS:  loReg[i] <= sysWrData;
          default:  loReg[i] <= loReg[i];
        endcase
      end
    end

    // R4: a half-word load leaves the low half cleared
    a_r4_load_clears_low: assert property (@(posedge clk) disable iff (rst)
      (strobe.loSrc[i] == SRC_XMEM || strobe.loSrc[i] == SRC_YMEM)
      |=> loReg[i][HALF_W-1:0] == '0);
  end

  for (genvar a = 0; a < NUM_ACC; a++) begin : g_guard
    always_ff @(posedge clk) begin
      if (rst) grdReg[a] <= '0;
      else begin
        case (strobe.grdSrc[a])
          SRC_ALU: grdReg[a] <= aluWrData[WIDE_W-1:BODY_W];
          SRC_SDT: grdReg[a] <= sdtGrdVal;
          SRC_SYS: grdReg[a] <= {GUARD_W{sysWrData[BODY_W-1]}};
          default: grdReg[a] <= grdReg[a];
        endcase
      end
    end

    // R7: guard-only write keeps the accumulator body
    a_r7_guard_only: assert property (@(posedge clk) disable iff (rst)
      (strobe.grdSrc[a] == SRC_SDT && strobe.loSrc[a] == SRC_NONE)
      |=> $stable(loReg[a]));
  end

  always_ff @(posedge clk) begin
    if (rst)               ctlReg <= '0;
    else if (strobe.ctlWr) ctlReg <= sysWrData;
  end

  // Read side (R2, R5, R9, R10)
  function automatic logic [WIDE_W-1:0] wideRead(input logic [SEL_W-1:0] s);
    if (int'(s) <= ACC_LAST) return {grdReg[s[0]], loReg[s]};
    return {{GUARD_W{loReg[s][BODY_W-1]}}, loReg[s]};
  endfunction

  assign aluRdDataA = wideRead(aluRdSelA);
  assign aluRdDataB = wideRead(aluRdSelB);
  assign xyStData   = (int'(xyStSel) <= ACC_LAST) ?
                      loReg[xyStSel][BODY_W-1:HALF_W] : '0;

  always_comb begin
    if (int'(sdtSel) < GRD_FIRST) begin
      sdtRdData = sdtLong ? loReg[sdtSel[SEL_W-1:0]] :
                  {{HALF_W{1'b0}}, loReg[sdtSel[SEL_W-1:0]][BODY_W-1:HALF_W]};
    end else if (int'(sdtSel) <= GRD_LAST) begin
      sdtRdData = {{(BODY_W-GUARD_W){grdReg[sdtSel[0]][GUARD_W-1]}},
                   grdReg[sdtSel[0]]};
    end else begin
      sdtRdData = '0;
    end
  end

  always_comb begin
    case (int'(sysSel))
      0:       sysRdData = ctlReg;
      1:       sysRdData = loReg[0];
      2, 3, 4, 5: sysRdData = loReg[sysSel];
      default: sysRdData = '0;
    endcase
  end

  // R1: reset clears every register
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (loReg == '0 && grdReg == '0 && ctlReg == '0));
  // R11: a vetoed cycle changes nothing
  a_r11_veto_freezes: assert property (@(posedge clk) disable iff (rst)
    strobe.veto |=> ($stable(loReg) && $stable(grdReg) && $stable(ctlReg)));
endmodule

// File: rtl/dsp_reg_bank.sv
module dsp_reg_bank
  import dsp_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     aluRdSelA,
  output logic [WIDE_W-1:0]    aluRdDataA,
  input  logic [SEL_W-1:0]     aluRdSelB,
  output logic [WIDE_W-1:0]    aluRdDataB,
  input  logic                 aluWrEn,
  input  logic [SEL_W-1:0]     aluWrSel,
  input  logic [WIDE_W-1:0]    aluWrData,
  input  logic                 xLdEn,
  input  logic [SEL_W-1:0]     xLdSel,
  input  logic [HALF_W-1:0]    xLdData,
  input  logic                 yLdEn,
  input  logic [SEL_W-1:0]     yLdSel,
  input  logic [HALF_W-1:0]    yLdData,
  input  logic                 xyStEn,
  input  logic [SEL_W-1:0]     xyStSel,
  output logic [HALF_W-1:0]    xyStData,
  input  logic                 sdtEn,
  input  logic                 sdtWrite,
  input  logic                 sdtLong,
  input  logic [SDT_SEL_W-1:0] sdtSel,
  input  logic [BODY_W-1:0]    sdtWrData,
  output logic [BODY_W-1:0]    sdtRdData,
  input  logic                 sysEn,
  input  logic                 sysWrite,
  input  logic [SEL_W-1:0]     sysSel,
  input  logic [BODY_W-1:0]    sysWrData,
  output logic [BODY_W-1:0]    sysRdData,
  output logic                 illegalFlag
);
  wr_strobe_t strobe;

  dsp_reg_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .aluWrEn(aluWrEn), .aluWrSel(aluWrSel),
    .xLdEn(xLdEn), .xLdSel(xLdSel),
    .yLdEn(yLdEn), .yLdSel(yLdSel),
    .xyStEn(xyStEn), .xyStSel(xyStSel),
    .sdtEn(sdtEn), .sdtWrite(sdtWrite), .sdtLong(sdtLong), .sdtSel(sdtSel),
    .sysEn(sysEn), .sysWrite(sysWrite), .sysSel(sysSel),
    .strobe(strobe), .illegalFlag(illegalFlag)
  );

  dsp_reg_data u_data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .aluRdSelA(aluRdSelA), .aluRdDataA(aluRdDataA),
    .aluRdSelB(aluRdSelB), .aluRdDataB(aluRdDataB),
    .aluWrData(aluWrData),
    .xLdData(xLdData), .yLdData(yLdData),
    .xyStSel(xyStSel), .xyStData(xyStData),
    .sdtLong(sdtLong), .sdtSel(sdtSel), .sdtWrData(sdtWrData),
    .sdtRdData(sdtRdData),
    .sysSel(sysSel), .sysWrData(sysWrData), .sysRdData(sysRdData)
  );
endmodule

// File: tb/test_dsp_reg_bank.sv
module test_dsp_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rst;
  logic [2:0]  aluRdSelA, aluRdSelB, aluWrSel, xLdSel, yLdSel, xyStSel, sysSel;
  logic [39:0] aluRdDataA, aluRdDataB, aluWrData;
  logic        aluWrEn, xLdEn, yLdEn, xyStEn, sdtEn, sdtWrite, sdtLong, sysEn, sysWrite;
  logic [15:0] xLdData, yLdData, xyStData;
  logic [3:0]  sdtSel;
  logic [31:0] sdtWrData, sdtRdData, sysWrData, sysRdData;
  logic        illegalFlag;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mLo [8];
  logic [7:0]  mG  [2];
  logic [31:0] mCtl;
  logic        mIll;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_reg_bank i_dsp_reg_bank (
    .clk(clk), .rst(rst),
    .aluRdSelA(aluRdSelA), .aluRdDataA(aluRdDataA),
    .aluRdSelB(aluRdSelB), .aluRdDataB(aluRdDataB),
    .aluWrEn(aluWrEn), .aluWrSel(aluWrSel), .aluWrData(aluWrData),
    .xLdEn(xLdEn), .xLdSel(xLdSel), .xLdData(xLdData),
    .yLdEn(yLdEn), .yLdSel(yLdSel), .yLdData(yLdData),
    .xyStEn(xyStEn), .xyStSel(xyStSel), .xyStData(xyStData),
    .sdtEn(sdtEn), .sdtWrite(sdtWrite), .sdtLong(sdtLong), .sdtSel(sdtSel),
    .sdtWrData(sdtWrData), .sdtRdData(sdtRdData),
    .sysEn(sysEn), .sysWrite(sysWrite), .sysSel(sysSel),
    .sysWrData(sysWrData), .sysRdData(sysRdData),
    .illegalFlag(illegalFlag)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [39:0] expWide(input logic [2:0] s);
    if (s < 2) return {mG[s[0]], mLo[s]};
    return {{8{mLo[s][31]}}, mLo[s]};
  endfunction

  function automatic logic [31:0] expSdt();
    if (sdtSel < 8) return sdtLong ? mLo[sdtSel[2:0]] : {16'h0, mLo[sdtSel[2:0]][31:16]};
    if (sdtSel < 10) return {{24{mG[sdtSel[0]][7]}}, mG[sdtSel[0]]};
    return 32'h0;
  endfunction

  function automatic logic [31:0] expSys();
    if (sysSel == 0) return mCtl;
    if (sysSel == 1) return mLo[0];
    if (sysSel < 6)  return mLo[sysSel];
    return 32'h0;
  endfunction

  // Compare all outputs, then advance the model to the post-edge state
  task automatic stepCycle(input string tag);
    logic viol;
    #1;
    check({tag, " R2/R3/R12 aluA"}, aluRdDataA, expWide(aluRdSelA));
    check({tag, " R2/R3/R12 aluB"}, aluRdDataB, expWide(aluRdSelB));
    check({tag, " R5 xyStData"}, {24'h0, xyStData}, (xyStSel < 2) ? {24'h0, mLo[xyStSel][31:16]} : 40'h0);
    check({tag, " R6/R7/R8/R9 sdtRd"}, {8'h0, sdtRdData}, {8'h0, expSdt()});
    check({tag, " R10 sysRd"}, {8'h0, sysRdData}, {8'h0, expSys()});
    check({tag, " R11 illegalFlag"}, {39'h0, illegalFlag}, {39'h0, mIll});
    viol = (xLdEn && !(xLdSel == 2 || xLdSel == 3)) ||
           (yLdEn && !(yLdSel == 4 || yLdSel == 5)) ||
           (xyStEn && xyStSel > 1) ||
           (sdtEn && (sdtSel > 9 || (sdtLong && sdtSel >= 8))) ||
           (sysEn && sysSel > 5);
    if (rst) begin
      foreach (mLo[k]) mLo[k] = 32'h0;
      mG[0] = 8'h0; mG[1] = 8'h0; mCtl = 32'h0; mIll = 1'b0;
    end else begin
      mIll = viol;
      if (!viol) begin
        if (aluWrEn) begin
          mLo[aluWrSel] = aluWrData[31:0];
          if (aluWrSel < 2) mG[aluWrSel[0]] = aluWrData[39:32];
        end
        if (xLdEn) mLo[xLdSel] = {xLdData, 16'h0};
        if (yLdEn) mLo[yLdSel] = {yLdData, 16'h0};
        if (sdtEn && sdtWrite) begin
          if (sdtSel >= 8) mG[sdtSel[0]] = sdtWrData[7:0];
          else if (sdtLong) begin
            mLo[sdtSel[2:0]] = sdtWrData;
            if (sdtSel < 2) mG[sdtSel[0]] = {8{sdtWrData[31]}};
          end else begin
            mLo[sdtSel[2:0]] = {sdtWrData[15:0], 16'h0};
            if (sdtSel < 2) mG[sdtSel[0]] = {8{sdtWrData[15]}};
          end
        end
        if (sysEn && sysWrite) begin
          if (sysSel == 0) mCtl = sysWrData;
          else if (sysSel == 1) begin mLo[0] = sysWrData; mG[0] = {8{sysWrData[31]}}; end
          else mLo[sysSel] = sysWrData;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic setIdle();
    aluWrEn = 0; xLdEn = 0; yLdEn = 0; xyStEn = 0; sdtEn = 0; sdtWrite = 0;
    sdtLong = 0; sysEn = 0; sysWrite = 0;
    aluWrSel = 0; xLdSel = 2; yLdSel = 4; xyStSel = 0; sdtSel = 0; sysSel = 0;
    aluWrData = 0; xLdData = 0; yLdData = 0; sdtWrData = 0; sysWrData = 0;
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 8; s += 2) begin
      setIdle();
      aluRdSelA = 3'(s); aluRdSelB = 3'(s + 1);
      sdtSel = 4'(8 + (s / 2) % 2);
      stepCycle(tag);
    end
  endtask

  function automatic logic [2:0] pick(input logic [2:0] lo, input logic [2:0] span);
    if (($urandom % 100) < 85) return lo + 3'($urandom % span);
    return 3'($urandom);
  endfunction

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (mLo[k]) mLo[k] = 32'h0;
    mG[0] = 0; mG[1] = 0; mCtl = 0; mIll = 0;
    setIdle();
    aluRdSelA = 0; aluRdSelB = 1;
    rst = 1'b1;
    @(negedge clk);
    stepCycle("R1 in reset");
    stepCycle("R1 in reset");
    rst = 1'b0;
    sweep("R1 after reset");

    // R3: 40-bit writes to ACC0 and XR0
    setIdle(); aluWrEn = 1; aluWrSel = 0; aluWrData = 40'hA5_8000_1234; stepCycle("R3 acc write");
    setIdle(); aluWrEn = 1; aluWrSel = 2; aluWrData = 40'h7F_9000_0001; stepCycle("R3 xr0 write");
    setIdle(); aluRdSelA = 0; aluRdSelB = 2; stepCycle("R2 read back");

    // R4: half-word loads, legal and illegal
    setIdle(); xLdEn = 1; xLdSel = 3; xLdData = 16'hBEEF;
    yLdEn = 1; yLdSel = 5; yLdData = 16'h1234; stepCycle("R4 xy load");
    setIdle(); aluRdSelA = 3; aluRdSelB = 5; stepCycle("R4 check");
    setIdle(); xLdEn = 1; xLdSel = 4; xLdData = 16'hFFFF; stepCycle("R4/R11 bad x target");
    setIdle(); aluRdSelA = 4; stepCycle("R11 no change");

    // R6/R7/R8: single transfers
    setIdle(); sdtEn = 1; sdtWrite = 1; sdtSel = 1; sdtWrData = 32'h0000_8001; stepCycle("R6 word acc");
    setIdle(); sdtEn = 1; sdtWrite = 1; sdtSel = 9; sdtWrData = 32'h0000_0042; stepCycle("R7 guard only");
    setIdle(); aluRdSelA = 1; stepCycle("R7 check");
    setIdle(); sdtEn = 1; sdtWrite = 1; sdtLong = 1; sdtSel = 0; sdtWrData = 32'h8765_4321; stepCycle("R8 long acc");
    setIdle(); sdtEn = 1; sdtWrite = 1; sdtLong = 1; sdtSel = 8; stepCycle("R8/R11 long guard");
    setIdle(); sdtEn = 1; sdtSel = 12; stepCycle("R8/R11 bad code");
    setIdle(); sdtLong = 1; sdtSel = 0; stepCycle("R9 long read");

    // R10: system path
    setIdle(); sysEn = 1; sysWrite = 1; sysSel = 1; sysWrData = 32'h8000_00FF; stepCycle("R10 acc0");
    setIdle(); sysEn = 1; sysWrite = 1; sysSel = 0; sysWrData = 32'hCAFE_F00D; stepCycle("R10 ctl");
    setIdle(); sysEn = 1; sysSel = 7; stepCycle("R10/R11 bad sel");

    // R12: collisions on the same register
    setIdle(); aluWrEn = 1; aluWrSel = 1; aluWrData = 40'h11_2222_3333;
    sdtEn = 1; sdtWrite = 1; sdtSel = 1; sdtWrData = 32'h0000_7777; aluRdSelA = 1; stepCycle("R12 alu vs sdt");
    setIdle(); aluWrEn = 1; aluWrSel = 0; aluWrData = 40'h33_4444_5555;
    sdtEn = 1; sdtWrite = 1; sdtSel = 8; sdtWrData = 32'h0000_00C3; aluRdSelA = 0; stepCycle("R12 guard split");
    setIdle(); aluWrEn = 1; aluWrSel = 2; aluWrData = 40'h0;
    xLdEn = 1; xLdSel = 2; xLdData = 16'h5A5A; sysEn = 1; sysWrite = 1; sysSel = 2;
    sysWrData = 32'h0BAD_0BAD; aluRdSelA = 2; stepCycle("R12 three way");
    sweep("R12 after");

    // Random phase across all paths
    for (int c = 0; c < RAND_CYCLES; c++) begin
      aluRdSelA = 3'($urandom); aluRdSelB = 3'($urandom);
      aluWrEn = 1'($urandom); aluWrSel = 3'($urandom);
      aluWrData = {8'($urandom), 32'($urandom)};
      xLdEn = (($urandom % 4) == 0); xLdSel = pick(2, 2); xLdData = 16'($urandom);
      yLdEn = (($urandom % 4) == 0); yLdSel = pick(4, 2); yLdData = 16'($urandom);
      xyStEn = (($urandom % 4) == 0); xyStSel = pick(0, 2);
      sdtEn = (($urandom % 3) == 0); sdtWrite = 1'($urandom); sdtLong = 1'($urandom);
      sdtSel = (($urandom % 100) < 90) ? 4'($urandom % 10) : 4'($urandom);
      sdtWrData = 32'($urandom);
      sysEn = (($urandom % 4) == 0); sysWrite = 1'($urandom); sysSel = pick(0, 6);
      sysWrData = 32'($urandom);
      stepCycle("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule